// File: doc/BRIEF.md
# Serial Dual-DAC Command Front End

This block is the digital side of a dual 8-bit voltage-output converter. A host writes 12-bit commands over a three-wire serial port: serial clock, data in, and an active-low select. The block decodes each command into two 8-bit code registers, a power state and per-channel output enables for the analog macros. A serial data output passes every input bit on after a fixed delay, so several devices can be chained on one select line.

The serial pins are oversampled by a system clock that runs at least four times faster than the serial clock. Each pin passes through a synchronizer, and the serial edges are found in the system clock domain. A command takes effect when the select line is released. Frames longer than twelve bits keep only their newest twelve bits. Frames shorter than twelve bits are dropped.

Top module: `dac_serial_front`

## Requirements
- R1: A frame is shifted in MSB first. Bits 11:10 are the channel address, bits 9:8 are the power code and bits 7:0 are the data. Address 01 loads channel A, address 10 loads channel B, and address 11 loads both channels with the same data.
- R2: A frame with address 00 changes no code, power or enable output.
- R3: Every frame with a nonzero address replaces the power state as a whole. Code 00 is normal operation, 01 powers down channel A (`pd_a`), 10 powers down channel B (`pd_b`) and 11 powers down the chip (`pd_all`). At most one of the three outputs is high at a time.
- R4: When more than twelve bits are clocked in during one select-low period, only the last twelve are decoded.
- R5: A frame with fewer than twelve bits sampled is discarded.
- R6: Register outputs change only after the select line rises, never while it is low.
- R7: While select is high, serial clock and data pin activity has no effect.
- R8: `dout` presents each sampled input bit twelve and a half serial clock periods after it was sampled. It changes only after a falling serial clock edge.
- R9: `dout` is always driven and keeps its last value while select is high.
- R10: After reset, both codes are zero, the power state is normal, both enables are low and `dout` is low.
- R11: A channel's enable is high only if that channel has been loaded since reset, the channel is not powered down and the chip is not powered down.
- R12: A 4-bit packet followed by an 8-bit packet, with the serial clock idling low between them under one select-low period, decodes the same as one 12-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_pin | input | 1 | Serial clock, idles low |
| csn_pin | input | 1 | Active-low frame select |
| din_pin | input | 1 | Serial data in, sampled on the rising serial clock edge |
| dout | output | 1 | Delayed serial data out, for chaining |
| code_a | output | 8 | Channel A converter code |
| code_b | output | 8 | Channel B converter code |
| pd_a | output | 1 | Channel A powered down |
| pd_b | output | 1 | Channel B powered down |
| pd_all | output | 1 | Whole chip powered down |
| oe_a | output | 1 | Channel A output enable |
| oe_b | output | 1 | Channel B output enable |

## Verification
The bench sends 16-bit frames. A design that kept the first twelve bits instead of the last twelve would load the padding into the address field. It sends short frames and split 4+8 packets, where a design that committed on a bit count instead of on select release would either apply garbage or lose the split frame. Each chained bit is compared one falling edge after the twelfth following sample, which catches a delay line that is one stage short or long. Serial clock toggling with select high would, in a design that did not gate on select, corrupt both `dout` and the frame buffer.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int ADDR_W  = 2;
  localparam int PD_W    = 2;
  localparam int DATA_W  = 8;
  localparam int NUM_CH  = ADDR_W;
  localparam int FRAME_W = ADDR_W + PD_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [PD_W-1:0]   pwr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dsf_edge.sv
module dsf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic csn_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_rise,
  output logic sel_fall
);
  logic sclk_q, csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  // serial edges only count while the frame is selected
  assign sclk_rise = sclk_s & ~sclk_q & ~csn_s;
  assign sclk_fall = ~sclk_s & sclk_q & ~csn_s;
  assign sel_rise  = csn_s & ~csn_q;
  assign sel_fall  = ~csn_s & csn_q;
endmodule

// File: rtl/dsf_shifter.sv
module dsf_shifter #(
  parameter int FRAME_W = 12,
  localparam int LINE_W = FRAME_W + 1,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din_s,
  input  logic               shift_en,
  input  logic               emit_en,
  input  logic               restart,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_full,
  output logic               dout
);
  logic [LINE_W-1:0] line_q, line_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dout_q, dout_d;

  always_comb begin
    line_d = line_q;
    cnt_d  = cnt_q;
    dout_d = dout_q;
    if (restart) cnt_d = '0;
    if (shift_en) begin
      line_d = {line_q[LINE_W-2:0], din_s};
      if (cnt_d != CNT_W'(FRAME_W)) cnt_d = cnt_d + 1'b1;
    end
    // oldest stage leaves half a serial period after the newest enters
    if (emit_en) dout_d = line_q[LINE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      cnt_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      line_q <= line_d;
      cnt_q  <= cnt_d;
      dout_q <= dout_d;
    end
  end

  assign frame      = line_q[FRAME_W-1:0];
  assign frame_full = (cnt_q == CNT_W'(FRAME_W));
  assign dout       = dout_q;
endmodule

// File: rtl/dsf_regs.sv
module dsf_regs
  import dsf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  cmd_t                          cmd,
  output logic [NUM_CH-1:0][DATA_W-1:0] code_q,
  output logic [NUM_CH-1:0]             chan_off,
  output logic                          chip_off,
  output logic [NUM_CH-1:0]             chan_oe
);
  logic [NUM_CH-1:0][DATA_W-1:0] code_d;
  logic [PD_W-1:0]               pwr_q, pwr_d;
  logic [NUM_CH-1:0]             wr_q, wr_d;
  logic                          apply;

  assign apply = commit && (cmd.addr != '0);

  always_comb begin
    code_d = code_q;
    pwr_d  = pwr_q;
    wr_d   = wr_q;
    if (apply) begin
      pwr_d = cmd.pwr;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (cmd.addr[ch]) begin
          code_d[ch] = cmd.data;
          wr_d[ch]   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pwr_q  <= '0;
      wr_q   <= '0;
    end else if (apply) begin
      code_q <= code_d;
      pwr_q  <= pwr_d;
      wr_q   <= wr_d;
    end
  end

  assign chip_off = (pwr_q == {PD_W{1'b1}});

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign chan_off[ch] = (pwr_q == PD_W'(1 << ch));
    assign chan_oe[ch]  = wr_q[ch] & ~chan_off[ch] & ~chip_off;
  end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dsf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_pin,
  input  logic              csn_pin,
  input  logic              din_pin,
  output logic              dout,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              pd_a,
  output logic              pd_b,
  output logic              pd_all,
  output logic              oe_a,
  output logic              oe_b
);
  logic [2:0]                    pins_s;
  logic                          sclk_s, csn_s, din_s;
  logic                          sclk_rise, sclk_fall, sel_rise, sel_fall;
  logic [FRAME_W-1:0]            frame_w;
  logic                          frame_full;
  logic [NUM_CH-1:0][DATA_W-1:0] code_w;
  logic [NUM_CH-1:0]             chan_off, chan_oe;
  logic                          chip_off;

  dsf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_pin, csn_pin, din_pin}),
    .q(pins_s)
  );
  assign {sclk_s, csn_s, din_s} = pins_s;

  dsf_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .csn_s(csn_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sel_rise(sel_rise), .sel_fall(sel_fall)
  );

  dsf_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .din_s(din_s),
    .shift_en(sclk_rise), .emit_en(sclk_fall), .restart(sel_fall),
    .frame(frame_w), .frame_full(frame_full), .dout(dout)
  );

  dsf_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(sel_rise & frame_full),
    .cmd(cmd_t'(frame_w)),
    .code_q(code_w), .chan_off(chan_off), .chip_off(chip_off), .chan_oe(chan_oe)
  );

  assign code_a = code_w[0];
  assign code_b = code_w[1];
  assign pd_a   = chan_off[0];
  assign pd_b   = chan_off[1];
  assign pd_all = chip_off;
  assign oe_a   = chan_oe[0];
  assign oe_b   = chan_oe[1];
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        csn_s,
  input logic        sclk_fall,
  input logic        sel_rise,
  input logic        frame_full,
  input logic [11:0] frame,
  input logic [7:0]  code_a,
  input logic [7:0]  code_b,
  input logic        pd_a,
  input logic        pd_b,
  input logic        pd_all,
  input logic        oe_a,
  input logic        oe_b,
  input logic        dout
);
  assert_code_a_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_a) |-> $past(sel_rise));
  assert_code_b_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_b) |-> $past(sel_rise));
  assert_noop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && frame_full && frame[11:10] == 2'b00) |=> ($stable(code_a) && $stable(code_b) && $stable(pd_all)));
  assert_power_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_a, pd_b, pd_all}));
  assert_oe_a_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_a |-> (!pd_a && !pd_all));
  assert_oe_b_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_b |-> (!pd_b && !pd_all));
  assert_dout_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(sclk_fall));
  assert_idle_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> $stable(frame));
endmodule

bind dac_serial_front dsf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sclk_fall(sclk_fall), .sel_rise(sel_rise),
  .frame_full(frame_full), .frame(frame_w), .code_a(code_a), .code_b(code_b),
  .pd_a(pd_a), .pd_b(pd_b), .pd_all(pd_all), .oe_a(oe_a), .oe_b(oe_b), .dout(dout)
);

// File: tb/dac_serial_front_test.sv
module dac_serial_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_pin = 1'b0, csn_pin = 1'b1, din_pin = 1'b0;
  logic dout, pd_a, pd_b, pd_all, oe_a, oe_b;
  logic [7:0] code_a, code_b;

  int n_chk = 0, n_bad = 0;
  logic [12:0] m_line = '0;
  int          m_cnt  = 0;
  logic        m_dout = 1'b0;
  logic [7:0]  e_code [2];
  logic [1:0]  e_pwr  = 2'b00;
  logic [1:0]  e_wr   = 2'b00;

  always #4 clk = ~clk;

  dac_serial_front uut (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .csn_pin(csn_pin), .din_pin(din_pin),
    .dout(dout), .code_a(code_a), .code_b(code_b), .pd_a(pd_a), .pd_b(pd_b),
    .pd_all(pd_all), .oe_a(oe_a), .oe_b(oe_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_oe(input int ch);
    return e_wr[ch] && (e_pwr != 2'(1 << ch)) && (e_pwr != 2'b11);
  endfunction

  task automatic chk_regs(input string req);
    chk({req, " code_a"}, 32'(code_a), 32'(e_code[0]));
    chk({req, " code_b"}, 32'(code_b), 32'(e_code[1]));
    chk({req, " power"}, 32'({pd_all, pd_b, pd_a}),
        32'({e_pwr == 2'b11, e_pwr == 2'b10, e_pwr == 2'b01}));
    chk({req, " enables R11"}, 32'({oe_b, oe_a}), 32'({exp_oe(1), exp_oe(0)}));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit check_dout);
    din_pin = b;
    wait_clk(4);
    sclk_pin = 1'b1;
    m_line = {m_line[11:0], b};
    if (m_cnt < 12) m_cnt++;
    wait_clk(4);
    sclk_pin = 1'b0;
    m_dout = m_line[12];
    wait_clk(3);
    if (check_dout) chk("R8 dout echo", 32'(dout), 32'(m_dout));
    wait_clk(1);
  endtask

  // send nbits of word MSB first; optional pause after the first 4 bits
  task automatic frame(input logic [15:0] word, input int nbits, input bit split);
    csn_pin = 1'b0;
    m_cnt = 0;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      send_bit(word[i], 1'b1);
      if (split && i == nbits - 4) wait_clk(20);
    end
    wait_clk(2);
    chk_regs("R6 before release");
    csn_pin = 1'b1;
    if (m_cnt >= 12 && m_line[11:10] != 2'b00) begin
      e_pwr = m_line[9:8];
      for (int ch = 0; ch < 2; ch++)
        if (m_line[10 + ch]) begin
          e_code[ch] = m_line[7:0];
          e_wr[ch]   = 1'b1;
        end
    end
    wait_clk(8);
  endtask

  task automatic noise_idle();
    for (int i = 0; i < 6; i++) begin
      din_pin = 1'($urandom);
      wait_clk(3);
      sclk_pin = ~sclk_pin;
    end
    sclk_pin = 1'b0;
    wait_clk(6);
    chk("R9 dout held while deselected", 32'(dout), 32'(m_dout));
    chk_regs("R7 deselected activity");
  endtask

  initial begin
    e_code[0] = '0;
    e_code[1] = '0;
    void'($urandom(32'd4711));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R10 reset dout", 32'(dout), 32'd0);
    chk_regs("R10 reset");

    frame({4'h0, 4'b01_00, 8'hA5}, 12, 1'b0);  chk_regs("R1 load A");
    frame({4'h0, 4'b10_00, 8'h3C}, 12, 1'b0);  chk_regs("R1 load B");
    frame({4'h0, 4'b11_00, 8'h7E}, 12, 1'b0);  chk_regs("R1 load both");
    frame({4'h0, 4'b00_11, 8'hFF}, 12, 1'b0);  chk_regs("R2 no-op");
    frame({4'h0, 4'b01_01, 8'h11}, 12, 1'b0);  chk_regs("R3 power down A");
    frame({4'h0, 4'b10_10, 8'h22}, 12, 1'b0);  chk_regs("R3 power down B");
    frame({4'h0, 4'b11_11, 8'h33}, 12, 1'b0);  chk_regs("R3 chip off");
    frame({4'h0, 4'b01_00, 8'h44}, 12, 1'b0);  chk_regs("R3 power replaced");
    frame({4'b1111, 4'b10_00, 8'h5A}, 16, 1'b0); chk_regs("R4 sixteen bits");
    frame({8'h00, 8'hC3}, 8, 1'b0);            chk_regs("R5 short frame");
    frame({4'h0, 4'b11_00, 8'h96}, 12, 1'b1);  chk_regs("R12 split packets");
    noise_idle();

    for (int n = 0; n < 60; n++) begin
      logic [15:0] w;
      int k;
      w = 16'($urandom);
      k = int'($urandom % 10);
      if (k < 6)       frame(w, 12, 1'b0);
      else if (k < 8)  frame(w, 16, 1'b0);
      else if (k == 8) frame(w, 1 + int'($urandom % 11), 1'b0);
      else             frame(w, 12, 1'b1);
      chk_regs("R1 R4 R5 random frame");
      if (n % 10 == 0) noise_idle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule